// File: doc/BRIEF.md
# Floppy Controller Command and Result Byte Handshake

This block is the host-facing byte protocol engine of a floppy disk controller. The host reaches it through one data port, which takes command bytes and returns reply bytes, and through a main status byte. The status byte shows whether the data port is ready, which way it is currently transferring, whether the controller is busy, whether a non-DMA execution is running, and which drive is stepping. The first byte of every command is an opcode. The block decodes it to learn how many parameter bytes follow and what reply, if any, the command produces.

No drive mechanics are modelled. Execution of a read, seek or recalibrate is a stub with a fixed latency of `EXEC_LAT` cycles. The read stub returns a reply built from its own parameters. Seek and recalibrate record a new cylinder for the addressed drive and raise an interrupt-pending flag, which a later sense-interrupt command reports and clears. A write to the data-rate-select port with bit 7 set acts as a software reset and returns everything to idle.

Top module: `fdc_cmd_port`

## Requirements
- R1: After reset or software reset the status byte reads 0x80: ready, direction host to controller, not busy. In that state data_out reads 0x00 and int_pending is 0.
- R2: Each opcode fixes the number of parameter bytes that follow it:
  - seek 0x0F takes 2;
  - recalibrate 0x07 takes 1;
  - specify 0x03 takes 2;
  - configure 0x13 takes 3;
  - read takes 8. A read is any opcode whose low five bits are 00110; the top three bits are option flags.
  - sense-interrupt 0x08 and register dump 0x0E take none.

  While parameters are being collected the status reads 0x90. After the last parameter of specify or configure the status returns to 0x80.
- R3: During a result phase the status reads 0xD0 and data_out presents the current reply byte. Each data_rd strobe advances to the next reply byte. Consuming the last byte returns the status to 0x80.
- R4: An opcode outside the set in R2 gives a result phase of exactly one byte, 0x80.
- R5: After its eighth parameter, a read spends EXEC_LAT cycles with status 0x30 and then returns seven bytes, in this order:
  - the low three bits of parameter 1;
  - 0x00;
  - 0x00;
  - parameters 2, 3, 4 and 5.
- R6: After its last parameter, a seek or recalibrate spends EXEC_LAT cycles with status bit 4 set and with the bit for the drive set among bits 3..0. The drive is given by bits 1..0 of parameter 1. The block then returns to 0x80 without a result phase, with int_pending at 1 and the drive's cylinder set: to parameter 2 for a seek, to 0 for a recalibrate.
- R7: A sense-interrupt issued while int_pending is 1 returns two bytes and clears int_pending. The first byte is 0x20 OR the drive number; the second is that drive's cylinder. Issued while int_pending is 0, it returns the single byte 0x80.
- R8: A register dump returns ten bytes:
  - the cylinders of drives 0 to 3;
  - the two specify parameters;
  - the three configure parameters;
  - 0x00.

  All of them are zero after reset.
- R9: A data_rd strobe outside a result phase is ignored, and so is a data_wr strobe during execution or a result phase. The status, data_out and the byte position are unchanged.
- R10: Writing the rate-select port with bit 7 set returns the block to the R1 state from any phase and clears the cylinders, stored parameters and int_pending. A write with bit 7 clear has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| data_wr | input | 1 | Write strobe for the data port |
| data_in | input | 8 | Command or parameter byte |
| data_rd | input | 1 | Read strobe for the data port |
| data_out | output | 8 | Current reply byte, 0x00 outside a result phase |
| dsr_wr | input | 1 | Write strobe for the rate-select port |
| dsr_in | input | 8 | Rate-select byte; bit 7 requests software reset |
| msr | output | 8 | Main status byte |
| int_pending | output | 1 | A seek or recalibrate outcome awaits sense-interrupt |

## Verification
The hardest situation to reach from the ports is a stray strobe that lands inside a multi-cycle execution window or in the middle of a reply stream. It has to arrive on a cycle the bench has counted from the final parameter byte. The stimulus issues the stray data_wr a fixed number of edges after the eighth read parameter. It then confirms that the status holds 0x30 for the rest of the latency window and that the reply begins unchanged. A second case puts a write halfway through the seven reply bytes. The software reset is applied with both settings of bit 7 while a seek outcome is pending and a new command is half entered, and a dump afterwards shows that the stored state was cleared.

// File: rtl/fdc_pkg.sv
package fdc_pkg;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_PARAM,
      PH_EXEC,
      PH_REPLY
   } phase_t;

   typedef enum logic [2:0] {
      K_SENSE,
      K_SEEK,
      K_RECAL,
      K_SPECIFY,
      K_CONFIG,
      K_READ,
      K_DUMP,
      K_BAD
   } kind_t;

   localparam logic [7:0] OPC_SENSE   = 8'h08;
   localparam logic [7:0] OPC_SEEK    = 8'h0F;
   localparam logic [7:0] OPC_RECAL   = 8'h07;
   localparam logic [7:0] OPC_SPECIFY = 8'h03;
   localparam logic [7:0] OPC_CONFIG  = 8'h13;
   localparam logic [7:0] OPC_DUMP    = 8'h0E;
   localparam logic [4:0] OPC_READ_LO = 5'h06;

   localparam logic [7:0] MSR_RQM  = 8'h80;
   localparam logic [7:0] MSR_DIO  = 8'h40;
   localparam logic [7:0] MSR_NDMA = 8'h20;
   localparam logic [7:0] MSR_CB   = 8'h10;

   localparam logic [7:0] REPLY_BAD    = 8'h80;
   localparam logic [7:0] ST0_SEEK_END = 8'h20;

   function automatic logic [3:0] kind_params(kind_t k);
      case (k)
         K_SEEK:    return 4'd2;
         K_RECAL:   return 4'd1;
         K_SPECIFY: return 4'd2;
         K_CONFIG:  return 4'd3;
         K_READ:    return 4'd8;
         default:   return 4'd0;
      endcase
   endfunction

endpackage

// File: rtl/fdc_op_decode.sv
module fdc_op_decode import fdc_pkg::*; #(
   parameter bit READ_FLAGS_MASKED = 1'b1
) (
   input  logic [7:0] opcode,
   output kind_t      kind,
   output logic [3:0] n_params
);

   logic read_hit;

   generate
      if (READ_FLAGS_MASKED) begin : g_masked
         assign read_hit = (opcode[4:0] == OPC_READ_LO);
      end else begin : g_exact
         assign read_hit = (opcode == {3'b000, OPC_READ_LO});
      end
   endgenerate

   always_comb begin
      if (read_hit) begin
         kind = K_READ;
      end else begin
         case (opcode)
            OPC_SENSE:   kind = K_SENSE;
            OPC_SEEK:    kind = K_SEEK;
            OPC_RECAL:   kind = K_RECAL;
            OPC_SPECIFY: kind = K_SPECIFY;
            OPC_CONFIG:  kind = K_CONFIG;
            OPC_DUMP:    kind = K_DUMP;
            default:     kind = K_BAD;
         endcase
      end
      n_params = kind_params(kind);
   end

endmodule

// File: rtl/fdc_msr_gen.sv
module fdc_msr_gen import fdc_pkg::*; #(
   parameter int NUM_DRIVES = 4
) (
   input  phase_t     phase,
   input  kind_t      kind,
   input  logic [1:0] drive,
   output logic [7:0] msr
);

   logic [3:0] drv_busy;

   always_comb begin
      drv_busy = '0;
      for (int i = 0; i < NUM_DRIVES; i++) begin
         if (phase == PH_EXEC && (kind == K_SEEK || kind == K_RECAL) &&
             drive == 2'(i)) begin
            drv_busy[i] = 1'b1;
         end
      end
      case (phase)
         PH_IDLE:  msr = MSR_RQM;
         PH_PARAM: msr = MSR_RQM | MSR_CB;
         PH_EXEC:  msr = (kind == K_READ) ? (MSR_NDMA | MSR_CB)
                                          : (MSR_CB | {4'b0000, drv_busy});
         default:  msr = MSR_RQM | MSR_DIO | MSR_CB;
      endcase
   end

endmodule

// File: rtl/fdc_reply_build.sv
module fdc_reply_build import fdc_pkg::*; #(
   parameter int MAX_PARAM  = 8,
   parameter int MAX_REPLY  = 10,
   parameter int NUM_DRIVES = 4
) (
   input  kind_t                                   kind,
   input  logic [MAX_PARAM-1:0][7:0]               params,
   input  logic                                    pend,
   input  logic [1:0]                              pend_drv,
   input  logic [NUM_DRIVES-1:0][7:0]              cyl,
   input  logic [1:0][7:0]                         spec,
   input  logic [2:0][7:0]                         cfg,
   output logic [MAX_REPLY-1:0][7:0]               reply,
   output logic [$clog2(MAX_REPLY+1)-1:0]          reply_len
);

   localparam int RLW = $clog2(MAX_REPLY + 1);

   logic [7:0] pend_cyl;
   logic       unused_params;

   assign unused_params = ^{params[0][7:3], params[MAX_PARAM-1:5]};

   always_comb begin
      pend_cyl = 8'h00;
      for (int i = 0; i < NUM_DRIVES; i++) begin
         if (pend_drv == 2'(i)) pend_cyl = cyl[i];
      end
   end

   always_comb begin
      reply     = '0;
      reply[0]  = REPLY_BAD;
      reply_len = RLW'(1);
      case (kind)
         K_SENSE: begin
            if (pend) begin
               reply[0]  = ST0_SEEK_END | {6'b000000, pend_drv};
               reply[1]  = pend_cyl;
               reply_len = RLW'(2);
            end
         end
         K_READ: begin
            reply[0] = {5'b00000, params[0][2:0]};
            reply[1] = 8'h00;
            reply[2] = 8'h00;
            for (int i = 0; i < 4; i++) reply[3+i] = params[1+i];
            reply_len = RLW'(7);
         end
         K_DUMP: begin
            reply[0] = 8'h00;
            for (int i = 0; i < NUM_DRIVES; i++) reply[i] = cyl[i];
            reply[4]  = spec[0];
            reply[5]  = spec[1];
            reply[6]  = cfg[0];
            reply[7]  = cfg[1];
            reply[8]  = cfg[2];
            reply[9]  = 8'h00;
            reply_len = RLW'(10);
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/fdc_cmd_port.sv
module fdc_cmd_port import fdc_pkg::*; #(
   parameter int MAX_PARAM         = 8,
   parameter int MAX_REPLY         = 10,
   parameter int EXEC_LAT          = 4,
   parameter int NUM_DRIVES        = 4,
   parameter bit READ_FLAGS_MASKED = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       data_wr,
   input  logic [7:0] data_in,
   input  logic       data_rd,
   output logic [7:0] data_out,
   input  logic       dsr_wr,
   input  logic [7:0] dsr_in,
   output logic [7:0] msr,
   output logic       int_pending
);

   localparam int RLW = $clog2(MAX_REPLY + 1);
   localparam int ECW = $clog2(EXEC_LAT + 1);

   generate
      if (MAX_PARAM < 8 || MAX_PARAM > 15) begin : g_bad_param
         $error("MAX_PARAM must lie in 8..15");
      end
      if (MAX_REPLY < 10) begin : g_bad_reply
         $error("MAX_REPLY must be at least 10");
      end
      if (EXEC_LAT < 1) begin : g_bad_lat
         $error("EXEC_LAT must be at least 1");
      end
      if (NUM_DRIVES < 1 || NUM_DRIVES > 4) begin : g_bad_drv
         $error("NUM_DRIVES must lie in 1..4");
      end
   endgenerate

   phase_t                        phase;
   kind_t                         kind_q, dec_kind, bld_kind;
   logic [3:0]                    need_q, dec_n, pcnt;
   logic [MAX_PARAM-1:0][7:0]     pbuf;
   logic [ECW-1:0]                ecnt;
   logic [MAX_REPLY-1:0][7:0]     rbuf, bld_reply;
   logic [RLW-1:0]                rlen, ridx, bld_len;
   logic                          pend;
   logic [1:0]                    pend_drv;
   logic [NUM_DRIVES-1:0][7:0]    cyl;
   logic [1:0][7:0]               spec;
   logic [2:0][7:0]               cfg;
   logic                          soft_rst;
   logic                          unused_dsr;

   assign soft_rst    = dsr_wr & dsr_in[7];
   assign unused_dsr  = ^dsr_in[6:0];
   assign bld_kind    = (phase == PH_IDLE) ? dec_kind : kind_q;
   assign int_pending = pend;

   fdc_op_decode #(.READ_FLAGS_MASKED(READ_FLAGS_MASKED)) u_dec (
      .opcode   (data_in),
      .kind     (dec_kind),
      .n_params (dec_n)
   );

   fdc_msr_gen #(.NUM_DRIVES(NUM_DRIVES)) u_msr (
      .phase (phase),
      .kind  (kind_q),
      .drive (pbuf[0][1:0]),
      .msr   (msr)
   );

   fdc_reply_build #(
      .MAX_PARAM  (MAX_PARAM),
      .MAX_REPLY  (MAX_REPLY),
      .NUM_DRIVES (NUM_DRIVES)
   ) u_bld (
      .kind      (bld_kind),
      .params    (pbuf),
      .pend      (pend),
      .pend_drv  (pend_drv),
      .cyl       (cyl),
      .spec      (spec),
      .cfg       (cfg),
      .reply     (bld_reply),
      .reply_len (bld_len)
   );

   always_comb begin
      data_out = 8'h00;
      for (int i = 0; i < MAX_REPLY; i++) begin
         if (phase == PH_REPLY && ridx == RLW'(i)) data_out = rbuf[i];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n || soft_rst) begin
         phase    <= PH_IDLE;
         kind_q   <= K_BAD;
         need_q   <= '0;
         pcnt     <= '0;
         pbuf     <= '0;
         ecnt     <= '0;
         rbuf     <= '0;
         rlen     <= '0;
         ridx     <= '0;
         pend     <= 1'b0;
         pend_drv <= '0;
         cyl      <= '0;
         spec     <= '0;
         cfg      <= '0;
      end else begin
         case (phase)
            PH_IDLE: begin
               if (data_wr) begin
                  kind_q <= dec_kind;
                  need_q <= dec_n;
                  pcnt   <= '0;
                  if (dec_n != 4'd0) begin
                     phase <= PH_PARAM;
                  end else begin
                     rbuf  <= bld_reply;
                     rlen  <= bld_len;
                     ridx  <= '0;
                     phase <= PH_REPLY;
                     if (dec_kind == K_SENSE) pend <= 1'b0;
                  end
               end
            end
            PH_PARAM: begin
               if (data_wr) begin
                  for (int i = 0; i < MAX_PARAM; i++) begin
                     if (pcnt == 4'(i)) pbuf[i] <= data_in;
                  end
                  if (pcnt == need_q - 4'd1) begin
                     ecnt <= '0;
                     case (kind_q)
                        K_SPECIFY: begin
                           spec  <= {data_in, pbuf[0]};
                           phase <= PH_IDLE;
                        end
                        K_CONFIG: begin
                           cfg   <= {data_in, pbuf[1], pbuf[0]};
                           phase <= PH_IDLE;
                        end
                        default: phase <= PH_EXEC;
                     endcase
                  end else begin
                     pcnt <= pcnt + 4'd1;
                  end
               end
            end
            PH_EXEC: begin
               if (ecnt == ECW'(EXEC_LAT - 1)) begin
                  if (kind_q == K_SEEK || kind_q == K_RECAL) begin
                     pend     <= 1'b1;
                     pend_drv <= pbuf[0][1:0];
                     for (int i = 0; i < NUM_DRIVES; i++) begin
                        if (pbuf[0][1:0] == 2'(i))
                           cyl[i] <= (kind_q == K_SEEK) ? pbuf[1] : 8'h00;
                     end
                     phase <= PH_IDLE;
                  end else begin
                     rbuf  <= bld_reply;
                     rlen  <= bld_len;
                     ridx  <= '0;
                     phase <= PH_REPLY;
                  end
               end else begin
                  ecnt <= ecnt + ECW'(1);
               end
            end
            default: begin
               if (data_rd) begin
                  if (ridx == rlen - RLW'(1)) phase <= PH_IDLE;
                  else                        ridx  <= ridx + RLW'(1);
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/fdc_cmd_port_chk.sv
module fdc_cmd_port_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       data_wr,
   input logic [7:0] data_in,
   input logic       data_rd,
   input logic [7:0] data_out,
   input logic       dsr_wr,
   input logic [7:0] dsr_in,
   input logic [7:0] msr,
   input logic       int_pending
);

   // R3
   dir_needs_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msr[6] |-> (msr[7] && msr[4]));

   // R9
   out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !msr[6] |-> (data_out == 8'h00));

   // R10
   soft_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (dsr_wr && dsr_in[7]) |=> (msr == 8'h80 && !int_pending));

   // R5
   read_exec_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      msr[5] |-> (msr[3:0] == 4'h0 && !msr[7]));

   // R2
   param_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr == 8'h80 && data_wr && data_in == 8'h0F && !(dsr_wr && dsr_in[7]))
      |=> (msr == 8'h90));

   // R9
   rd_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr[7:6] == 2'b10 && data_rd && !data_wr && !dsr_wr)
      |=> ($stable(msr) && $stable(int_pending)));

   // R7
   sense_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (msr == 8'h80 && data_wr && data_in == 8'h08 && !(dsr_wr && dsr_in[7]))
      |=> !int_pending);

endmodule

bind fdc_cmd_port fdc_cmd_port_chk u_chk (.*);

// File: tb/fdc_cmd_port_tb.sv
`timescale 1ns/1ps
module fdc_cmd_port_tb;

   localparam int EXEC_LAT = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       data_wr = 1'b0;
   logic [7:0] data_in = 8'h00;
   logic       data_rd = 1'b0;
   logic [7:0] data_out;
   logic       dsr_wr = 1'b0;
   logic [7:0] dsr_in = 8'h00;
   logic [7:0] msr;
   logic       int_pending;

   always #2 clk = ~clk;

   fdc_cmd_port #(.EXEC_LAT(EXEC_LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .data_in(data_in),
      .data_rd(data_rd), .data_out(data_out), .dsr_wr(dsr_wr),
      .dsr_in(dsr_in), .msr(msr), .int_pending(int_pending)
   );

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   task automatic check8(string req, string what, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%02h expected=%02h at %0t", req, what, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int         m_phase;   // 0 idle, 1 params, 2 exec, 3 reply
   int         m_kind;    // 0 sense 1 seek 2 recal 3 spec 4 cfg 5 read 6 dump 7 bad
   int         m_need;
   int         m_exec;
   bit         m_pend;
   int         m_pdrv;
   logic [7:0] m_params[$];
   logic [7:0] m_reply[$];
   logic [7:0] m_cyl[4];
   logic [7:0] m_spec[2];
   logic [7:0] m_cfg[3];

   function automatic int classify(logic [7:0] op);
      if (op[4:0] == 5'h06) return 5;
      case (op)
         8'h08: return 0;
         8'h0F: return 1;
         8'h07: return 2;
         8'h03: return 3;
         8'h13: return 4;
         8'h0E: return 6;
         default: return 7;
      endcase
   endfunction

   function automatic int nparams(int k);
      case (k)
         1: return 2;
         2: return 1;
         3: return 2;
         4: return 3;
         5: return 8;
         default: return 0;
      endcase
   endfunction

   task automatic m_reset();
      m_phase = 0; m_kind = 7; m_need = 0; m_exec = 0;
      m_pend = 1'b0; m_pdrv = 0;
      m_params.delete(); m_reply.delete();
      for (int i = 0; i < 4; i++) m_cyl[i] = 8'h00;
      m_spec[0] = 8'h00; m_spec[1] = 8'h00;
      for (int i = 0; i < 3; i++) m_cfg[i] = 8'h00;
   endtask

   task automatic m_make_reply(int k);
      m_reply.delete();
      case (k)
         0: if (m_pend) begin
               m_reply.push_back(8'h20 | 8'(m_pdrv));
               m_reply.push_back(m_cyl[m_pdrv]);
            end else m_reply.push_back(8'h80);
         5: begin
               m_reply.push_back(m_params[0] & 8'h07);
               m_reply.push_back(8'h00);
               m_reply.push_back(8'h00);
               for (int i = 1; i <= 4; i++) m_reply.push_back(m_params[i]);
            end
         6: begin
               for (int i = 0; i < 4; i++) m_reply.push_back(m_cyl[i]);
               m_reply.push_back(m_spec[0]); m_reply.push_back(m_spec[1]);
               for (int i = 0; i < 3; i++) m_reply.push_back(m_cfg[i]);
               m_reply.push_back(8'h00);
            end
         default: m_reply.push_back(8'h80);
      endcase
   endtask

   initial m_reset();

   always @(posedge clk) begin
      if (!rst_n || (dsr_wr && dsr_in[7])) begin
         m_reset();
      end else begin
         case (m_phase)
            0: if (data_wr) begin
                  m_kind = classify(data_in);
                  m_need = nparams(m_kind);
                  m_params.delete();
                  if (m_need > 0) m_phase = 1;
                  else begin
                     m_make_reply(m_kind);
                     if (m_kind == 0) m_pend = 1'b0;
                     m_phase = 3;
                  end
               end
            1: if (data_wr) begin
                  m_params.push_back(data_in);
                  if (m_params.size() == m_need) begin
                     if (m_kind == 3) begin
                        m_spec[0] = m_params[0]; m_spec[1] = m_params[1]; m_phase = 0;
                     end else if (m_kind == 4) begin
                        for (int i = 0; i < 3; i++) m_cfg[i] = m_params[i];
                        m_phase = 0;
                     end else begin
                        m_exec = 0; m_phase = 2;
                     end
                  end
               end
            2: begin
                  m_exec++;
                  if (m_exec == EXEC_LAT) begin
                     if (m_kind == 5) begin
                        m_make_reply(5); m_phase = 3;
                     end else begin
                        m_pend = 1'b1;
                        m_pdrv = int'(m_params[0][1:0]);
                        m_cyl[m_pdrv] = (m_kind == 1) ? m_params[1] : 8'h00;
                        m_phase = 0;
                     end
                  end
               end
            default: if (data_rd) begin
                  void'(m_reply.pop_front());
                  if (m_reply.size() == 0) m_phase = 0;
               end
         endcase
      end
   end

   function automatic logic [7:0] m_msr();
      case (m_phase)
         0: return 8'h80;
         1: return 8'h90;
         2: return (m_kind == 5) ? 8'h30 : (8'h10 | (8'h01 << m_params[0][1:0]));
         default: return 8'hD0;
      endcase
   endfunction

   always @(negedge clk) begin
      if (rst_n && !done) begin
         case (m_phase)
            0: check8("R1", "model msr", msr, m_msr());
            1: check8("R2", "model msr", msr, m_msr());
            2: check8(m_kind == 5 ? "R5" : "R6", "model msr", msr, m_msr());
            default: check8("R3", "model msr", msr, m_msr());
         endcase
         check8("R3", "model data_out", data_out,
                (m_phase == 3 && m_reply.size() > 0) ? m_reply[0] : 8'h00);
         check8("R7", "model int_pending", {7'b0, int_pending}, {7'b0, m_pend});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(logic [7:0] b);
      @(negedge clk); data_wr = 1'b1; data_in = b;
      @(negedge clk); data_wr = 1'b0;
   endtask

   task automatic wr_dsr(logic [7:0] b);
      @(negedge clk); dsr_wr = 1'b1; dsr_in = b;
      @(negedge clk); dsr_wr = 1'b0;
   endtask

   task automatic rd_expect(string req, logic [7:0] exp);
      @(negedge clk);
      check8(req, "reply byte", data_out, exp);
      data_rd = 1'b1;
      @(negedge clk); data_rd = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; failures++;
         $display("FAIL R1 watchdog actual=hung expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check8("R1", "msr after reset", msr, 8'h80);
      check8("R1", "data_out after reset", data_out, 8'h00);
      check8("R1", "int after reset", {7'b0, int_pending}, 8'h00);

      // R8 dump of reset state
      wr(8'h0E);
      check8("R3", "msr in reply", msr, 8'hD0);
      for (int i = 0; i < 10; i++) rd_expect("R8", 8'h00);
      check8("R3", "msr after last reply", msr, 8'h80);

      // R7 sense with nothing pending
      wr(8'h08);
      rd_expect("R7", 8'h80);
      check8("R7", "msr after lone sense", msr, 8'h80);

      // R4 invalid opcode
      wr(8'h55);
      check8("R4", "msr invalid", msr, 8'hD0);
      rd_expect("R4", 8'h80);
      check8("R4", "msr after invalid", msr, 8'h80);

      // R9 read while idle
      @(negedge clk); data_rd = 1'b1;
      @(negedge clk); data_rd = 1'b0;
      check8("R9", "msr after idle read", msr, 8'h80);
      check8("R9", "data_out after idle read", data_out, 8'h00);

      // R2 specify and configure
      wr(8'h03);
      check8("R2", "msr specify param", msr, 8'h90);
      wr(8'hAB);
      check8("R2", "msr specify param 2", msr, 8'h90);
      wr(8'hCD);
      check8("R2", "msr after specify", msr, 8'h80);
      wr(8'h13); wr(8'h00); wr(8'h5A);
      check8("R2", "msr configure mid", msr, 8'h90);
      wr(8'h07);
      check8("R2", "msr after configure", msr, 8'h80);

      // R6 seek drive 2 to cylinder 0x25
      wr(8'h0F); wr(8'h02);
      check8("R2", "msr seek param", msr, 8'h90);
      wr(8'h25);
      check8("R6", "msr seek exec", msr, 8'h14);
      repeat (EXEC_LAT - 1) @(negedge clk);
      check8("R6", "msr seek exec end", msr, 8'h14);
      @(negedge clk);
      check8("R6", "msr after seek", msr, 8'h80);
      check8("R6", "int after seek", {7'b0, int_pending}, 8'h01);

      // R7 sense reports the seek
      wr(8'h08);
      rd_expect("R7", 8'h22);
      rd_expect("R7", 8'h25);
      check8("R7", "int cleared", {7'b0, int_pending}, 8'h00);

      // R6 recalibrate drive 1
      wr(8'h07); wr(8'h01);
      check8("R6", "msr recal exec", msr, 8'h12);
      repeat (EXEC_LAT) @(negedge clk);
      check8("R6", "msr after recal", msr, 8'h80);
      check8("R6", "int after recal", {7'b0, int_pending}, 8'h01);
      wr(8'h08);
      rd_expect("R7", 8'h21);
      rd_expect("R7", 8'h00);

      // R8 dump with stored state
      wr(8'h0E);
      rd_expect("R8", 8'h00); rd_expect("R8", 8'h00);
      rd_expect("R8", 8'h25); rd_expect("R8", 8'h00);
      rd_expect("R8", 8'hAB); rd_expect("R8", 8'hCD);
      rd_expect("R8", 8'h00); rd_expect("R8", 8'h5A);
      rd_expect("R8", 8'h07); rd_expect("R8", 8'h00);

      // R5 read with option flags, stray writes ignored (R9)
      wr(8'hE6);
      wr(8'h05); wr(8'h11); wr(8'h01); wr(8'h09);
      wr(8'h02); wr(8'h12); wr(8'h1B); wr(8'hFF);
      check8("R5", "msr read exec", msr, 8'h30);
      wr(8'h08);
      repeat (EXEC_LAT - 3) @(negedge clk);
      check8("R9", "msr exec after stray write", msr, 8'h30);
      @(negedge clk);
      check8("R5", "msr read reply", msr, 8'hD0);
      rd_expect("R5", 8'h05); rd_expect("R5", 8'h00); rd_expect("R5", 8'h00);
      wr(8'h55);
      check8("R9", "msr reply after stray write", msr, 8'hD0);
      rd_expect("R5", 8'h11); rd_expect("R5", 8'h01);
      rd_expect("R5", 8'h09); rd_expect("R5", 8'h02);
      check8("R5", "msr after read", msr, 8'h80);

      // R10 software reset
      wr(8'h0F); wr(8'h01); wr(8'h40);
      repeat (EXEC_LAT) @(negedge clk);
      check8("R6", "int before reset", {7'b0, int_pending}, 8'h01);
      wr(8'h0F);
      wr_dsr(8'h02);
      check8("R10", "msr after bit7 clear", msr, 8'h90);
      check8("R10", "int after bit7 clear", {7'b0, int_pending}, 8'h01);
      wr_dsr(8'h80);
      check8("R10", "msr after soft reset", msr, 8'h80);
      check8("R10", "int after soft reset", {7'b0, int_pending}, 8'h00);
      wr(8'h0E);
      for (int i = 0; i < 10; i++) rd_expect("R10", 8'h00);
      wr(8'h0E);
      rd_expect("R10", 8'h00);
      wr_dsr(8'h81);
      check8("R10", "msr reset mid reply", msr, 8'h80);
      check8("R10", "data_out reset mid reply", data_out, 8'h00);

      repeat (2) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule